// File: doc/BRIEF.md
# SPI Slave Register Access Engine

This block is a mode-0 SPI slave that gives an external host byte-wide access to a small register map held elsewhere in the chip. Every frame opens with a fixed identification byte. A command byte follows, carrying an opcode in its upper nibble and a starting register pointer in its lower nibble. After that, data bytes stream in or out, and the pointer advances after each byte. The engine does not store registers itself. It raises a one-cycle read or write strobe toward the core, with an address and, for a write, a data byte. The core reports a busy condition, and while that condition holds, write strobes are suppressed.

The serial pins are oversampled in the system clock domain. That clock must run at least four times the SCK frequency. The data output is open drain: the block can only pull the line low, and everything else is left to an external pull-up.

Top module: `spi_reg_engine`

## Requirements
- R1: After reset, no frame is accepted until a high-to-low transition of csN is seen. If csN is already low when reset is released, the whole frame is ignored: no strobe fires and sdoPullLow stays 0.
- R2: The first byte of a frame must equal 8'h50, received MSB first. With any other value, the rest of the frame produces no strobe and no SDO activity until csN rises.
- R3: The second byte holds the opcode in bits 7:4 and the start address in bits 3:0. Opcode 4'b1011 is a read and 4'b1100 is a write. Every other opcode makes the rest of the frame a no-op.
- R4: In a write frame, each complete data byte is sampled on rising SCK edges, MSB first. Each such byte produces one regWrStrb pulse, with regAddr set to the current pointer and regWrData set to the byte.
- R5: After each data byte, the pointer advances by one. From address 6 it wraps to 0. Above 6 it counts modulo 16, so 15 is followed by 0.
- R6: A read frame raises regRdStrb for the start address when the command byte completes, and again for each following address when each data byte completes. The register byte is shifted out MSB first, one bit per falling SCK edge. The MSB appears on the falling edge that ends the command byte, and streaming continues while SCK runs.
- R7: sdoPullLow is 1 only for a 0 data bit during the data phase of a read frame while csN is low. It is 0 during the identification and command bytes, for 1 bits, and whenever csN is high.
- R8: A data byte that completes while busy is 1 produces no write strobe, but the pointer still advances. Reads are unaffected by busy.
- R9: A rising csN ends the frame at once. A partially received byte is discarded without a strobe, and the next frame starts again from the identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| sdi | input | 1 | SPI serial data from host |
| sdoPullLow | output | 1 | 1 pulls the open-drain SDO line low; 0 releases it |
| busy | input | 1 | Core busy; blocks write strobes |
| regRdData | input | 8 | Register byte from the core, sampled in the regRdStrb cycle |
| regRdStrb | output | 1 | One-cycle register read request |
| regWrStrb | output | 1 | One-cycle register write request |
| regAddr | output | 4 | Register address for the current strobe |
| regWrData | output | 8 | Data byte for a write strobe |

## Verification
The assertions take for granted that SCK stays low for at least two system clocks in each period. They also assume csN stays low for several system clocks after the last rising SCK edge of a frame, and that csN is never re-lowered within a few cycles of rising. The SDO timing and strobe-inside-frame properties depend on these margins. The stimulus drives SCK with four system clocks per half period. It holds csN low for six clocks on both sides of each frame and keeps csN high for eight clocks between frames. It changes busy only between bytes, after the last falling SCK edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int OP_W   = BYTE_W - ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_SKIP
  } ctrlState_t;

  // Strobes from the control FSM to the datapath, valid for one clock.
  typedef struct packed {
    logic frameStart;  // new frame: release SDO
    logic loadPtr;     // take pointer from the command byte
    logic stepPtr;     // advance pointer after a data byte
    logic readReq;     // issue a read strobe
    logic writeReq;    // issue a write strobe
    logic shiftOut;    // present next SDO bit
    logic readPhase;   // data phase of a read frame
  } dpCmd_t;

endpackage

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WRAP_ADDR   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              sckFall,
  output logic              csFall,
  output logic              csHigh,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRdStrb,
  output logic              regWrStrb,
  output logic [BYTE_W-1:0] regWrData,
  output logic              sdoPullLow
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [ADDR_W-1:0] WRAP_PT = ADDR_W'(WRAP_ADDR);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

  // ---- input synchronizers: {cs, sdi, sck} ----
  logic [2:0] syncPipe [SYNC_STAGES];
  logic       sckPrev, csPrev;
  logic       sckS, sdiS, csS, sckRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      sckPrev <= 1'b0;
      csPrev  <= 1'b0;
    end else begin
      syncPipe[0] <= {csN, sdi, sck};
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  assign csS     = syncPipe[SYNC_STAGES-1][2];
  assign sdiS    = syncPipe[SYNC_STAGES-1][1];
  assign sckS    = syncPipe[SYNC_STAGES-1][0];
  assign csHigh  = csS;
  assign csFall  = !csS && csPrev;
  assign sckRise = sckS && !sckPrev && !csS;
  assign sckFall = !sckS && sckPrev && !csS;

  // ---- receive shifter ----
  logic [BYTE_W-1:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;

  assign rxByte   = {rxShift[BYTE_W-2:0], sdiS};
  assign byteDone = sckRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (csHigh) begin
      bitCnt  <= '0;
    end else if (sckRise) begin
      rxShift <= rxByte;
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // ---- register pointer and core strobes ----
  logic [ADDR_W-1:0] ptr, nextPtr, cmdAddr, strbAddr;

  assign nextPtr  = (ptr == WRAP_PT) ? '0 : ptr + 1'b1;
  assign cmdAddr  = rxByte[ADDR_W-1:0];
  assign strbAddr = cmd.loadPtr ? cmdAddr : (cmd.readReq ? nextPtr : ptr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      regAddr   <= '0;
      regRdStrb <= 1'b0;
      regWrStrb <= 1'b0;
      regWrData <= '0;
    end else begin
      regRdStrb <= cmd.readReq;
      regWrStrb <= cmd.writeReq;
      if (cmd.loadPtr)      ptr <= cmdAddr;
      else if (cmd.stepPtr) ptr <= nextPtr;
      if (cmd.readReq || cmd.writeReq) regAddr <= strbAddr;
      if (cmd.writeReq) regWrData <= rxByte;
    end
  end

  // ---- transmit shifter (changes on falling SCK) ----
  logic [BYTE_W-1:0] txShift;
  logic              sdoBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      sdoBit  <= 1'b1;
    end else begin
      if (cmd.frameStart) begin
        sdoBit  <= 1'b1;
        txShift <= '1;
      end else if (regRdStrb) begin
        txShift <= regRdData;
      end else if (cmd.shiftOut) begin
        sdoBit  <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      end
    end
  end

  assign sdoPullLow = cmd.readPhase && !sdoBit && !csN;

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_CODE  = 8'h50,
  parameter logic [OP_W-1:0]   OP_READ  = 4'hB,
  parameter logic [OP_W-1:0]   OP_WRITE = 4'hC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              sckFall,
  input  logic              csFall,
  input  logic              csHigh,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd
);

  ctrlState_t state, stateNxt;
  logic [OP_W-1:0] opcode;

  assign opcode = rxByte[BYTE_W-1:ADDR_W];

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    cmd.readPhase = (state == ST_READ);
    if (csHigh) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            stateNxt       = ST_ID;
            cmd.frameStart = 1'b1;
          end
        end
        ST_ID: begin
          if (byteDone) stateNxt = (rxByte == ID_CODE) ? ST_CMD : ST_SKIP;
        end
        ST_CMD: begin
          if (byteDone) begin
            if (opcode == OP_READ) begin
              stateNxt    = ST_READ;
              cmd.loadPtr = 1'b1;
              cmd.readReq = 1'b1;
            end else if (opcode == OP_WRITE) begin
              stateNxt    = ST_WRITE;
              cmd.loadPtr = 1'b1;
            end else begin
              stateNxt = ST_SKIP;
            end
          end
        end
        ST_READ: begin
          cmd.shiftOut = sckFall;
          if (byteDone) begin
            cmd.stepPtr = 1'b1;
            cmd.readReq = 1'b1;
          end
        end
        ST_WRITE: begin
          if (byteDone) begin
            cmd.stepPtr  = 1'b1;
            cmd.writeReq = !busy;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                WRAP_ADDR   = 6,
  parameter logic [BYTE_W-1:0] ID_CODE     = 8'h50,
  parameter logic [OP_W-1:0]   OP_READ     = 4'hB,
  parameter logic [OP_W-1:0]   OP_WRITE    = 4'hC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdoPullLow,
  input  logic              busy,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              regRdStrb,
  output logic              regWrStrb,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData
);

  dpCmd_t            cmd;
  logic              sckFall, csFall, csHigh, byteDone;
  logic [BYTE_W-1:0] rxByte;

  spi_reg_ctrl #(
    .ID_CODE (ID_CODE),
    .OP_READ (OP_READ),
    .OP_WRITE(OP_WRITE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busy    (busy),
    .sckFall (sckFall),
    .csFall  (csFall),
    .csHigh  (csHigh),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .cmd     (cmd)
  );

  spi_reg_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .WRAP_ADDR  (WRAP_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .sdi       (sdi),
    .cmd       (cmd),
    .regRdData (regRdData),
    .sckFall   (sckFall),
    .csFall    (csFall),
    .csHigh    (csHigh),
    .byteDone  (byteDone),
    .rxByte    (rxByte),
    .regAddr   (regAddr),
    .regRdStrb (regRdStrb),
    .regWrStrb (regWrStrb),
    .regWrData (regWrData),
    .sdoPullLow(sdoPullLow)
  );

endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic busy,
  input logic sdoPullLow,
  input logic regRdStrb,
  input logic regWrStrb
);

  // R8: a write strobe follows a cycle in which busy was low
  assert_wr_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrb |-> !$past(busy));

  // R6: read and write requests never coincide
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regRdStrb, regWrStrb}));

  // R9: strobes only come out of a frame that is still open
  assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdStrb || regWrStrb) |-> !$past(csN));

  // R7: within a frame, SDO moves only while SCK is low
  assert_sdo_on_low_sck_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && (sdoPullLow != $past(sdoPullLow))) |-> !$past(sck));

endmodule

bind spi_reg_engine spi_reg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .sck       (sck),
  .busy      (busy),
  .sdoPullLow(sdoPullLow),
  .regRdStrb (regRdStrb),
  .regWrStrb (regWrStrb)
);

// File: tb/spi_reg_engine_tb.sv
module spi_reg_engine_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b0;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       busy = 1'b0;
  logic       sdoPullLow;
  logic       regRdStrb, regWrStrb;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_engine u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdoPullLow(sdoPullLow), .busy(busy), .regRdData(regRdData),
    .regRdStrb(regRdStrb), .regWrStrb(regWrStrb),
    .regAddr(regAddr), .regWrData(regWrData)
  );

  // core-side register model and strobe log
  logic [7:0] mem [16];
  int wrCnt = 0, rdCnt = 0;
  logic [3:0] wrAddrLog [256];
  logic [7:0] wrDataLog [256];
  logic [3:0] rdAddrLog [256];

  function automatic logic [7:0] initVal(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  assign regRdData = mem[regAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= initVal(i);
    end else begin
      if (regWrStrb) begin
        mem[regAddr] <= regWrData;
        wrAddrLog[wrCnt & 255] <= regAddr;
        wrDataLog[wrCnt & 255] <= regWrData;
        wrCnt <= wrCnt + 1;
      end
      if (regRdStrb) begin
        rdAddrLog[rdCnt & 255] <= regAddr;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'hFF;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = tx[i];
      repeat (4) @(posedge clk);
      #1;
      rx[i] = !sdoPullLow;
      sck = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic frameOpen();
    #1 csN = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic frameClose();
    repeat (6) @(posedge clk);
    #1 csN = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic writeFrame(input logic [7:0] idb, input logic [7:0] cmdb,
                            input logic [7:0] d0);
    logic [7:0] rx;
    frameOpen();
    xfer(idb, rx);
    xfer(cmdb, rx);
    xfer(d0, rx);
    frameClose();
  endtask

  task automatic readOne(input logic [3:0] a, output logic [7:0] rx);
    logic [7:0] r0;
    frameOpen();
    xfer(8'h50, r0);
    xfer({4'hB, a}, r0);
    xfer(8'h00, rx);
    frameClose();
  endtask

  initial begin
    logic [7:0] expMem [16];
    logic [7:0] rx;
    int w0, r0;
    for (int i = 0; i < 16; i++) expMem[i] = initVal(i);

    // reset with csN already low
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(sdoPullLow == 1'b0, "R1 reset sdo", sdoPullLow, 0);
    check(wrCnt == 0 && rdCnt == 0, "R1 reset strobes", wrCnt + rdCnt, 0);
    xfer(8'h50, rx);
    xfer(8'hC2, rx);
    xfer(8'hAA, rx);
    repeat (6) @(posedge clk);
    check(wrCnt == 0, "R1 no frame without csN fall", wrCnt, 0);
    #1 csN = 1'b1;
    repeat (8) @(posedge clk);

    // single write
    writeFrame(8'h50, 8'hC2, 8'h3C);
    expMem[2] = 8'h3C;
    check(wrCnt == 1, "R4 write count", wrCnt, 1);
    check(wrAddrLog[0] == 4'd2, "R4 write addr", wrAddrLog[0], 2);
    check(wrDataLog[0] == 8'h3C, "R4 write data", wrDataLog[0], 8'h3C);

    // single read, SDO released in header bytes
    frameOpen();
    xfer(8'h50, rx);
    check(rx == 8'hFF, "R7 released during id", rx, 8'hFF);
    xfer(8'hB2, rx);
    check(rx == 8'hFF, "R7 released during command", rx, 8'hFF);
    xfer(8'h00, rx);
    check(rx == expMem[2], "R6 read data", rx, expMem[2]);
    check(rdAddrLog[0] == 4'd2, "R6 read addr", rdAddrLog[0], 2);
    frameClose();
    check(sdoPullLow == 1'b0, "R7 released with csN high", sdoPullLow, 0);

    // wrong identification bytes
    foreach (expMem[k]) if (k < 6) begin
      logic [7:0] badId;
      badId = (k == 0) ? 8'h51 : (k == 1) ? 8'h10 : (k == 2) ? 8'hD0 :
              (k == 3) ? 8'h40 : (k == 4) ? 8'h00 : 8'h58;
      w0 = wrCnt; r0 = rdCnt;
      writeFrame(badId, 8'hC0, 8'h55);
      check(wrCnt == w0, "R2 bad id write ignored", wrCnt, w0);
      frameOpen();
      xfer(badId, rx);
      xfer(8'hB0, rx);
      xfer(8'h00, rx);
      frameClose();
      check(rdCnt == r0 && rx == 8'hFF, "R2 bad id read ignored", rx, 8'hFF);
    end

    // all illegal opcodes
    for (int op = 0; op < 16; op++) begin
      if (op != 11 && op != 12) begin
        w0 = wrCnt; r0 = rdCnt;
        frameOpen();
        xfer(8'h50, rx);
        xfer({4'(op), 4'h1}, rx);
        xfer(8'h00, rx);
        frameClose();
        check(wrCnt == w0 && rdCnt == r0 && rx == 8'hFF, "R3 illegal opcode no-op",
              rx, 8'hFF);
      end
    end

    // streaming write from 5 wraps after 6
    w0 = wrCnt;
    frameOpen();
    xfer(8'h50, rx);
    xfer(8'hC5, rx);
    for (int k = 0; k < 4; k++) xfer(8'hA0 + 8'(k), rx);
    frameClose();
    check(wrCnt == w0 + 4, "R5 stream write count", wrCnt, w0 + 4);
    for (int k = 0; k < 4; k++) begin
      int ea;
      ea = (5 + k > 6) ? (5 + k - 7) : (5 + k);
      check(wrAddrLog[(w0 + k) & 255] == 4'(ea), "R5 wrapped write addr",
            wrAddrLog[(w0 + k) & 255], ea);
      check(wrDataLog[(w0 + k) & 255] == 8'hA0 + 8'(k), "R4 stream data",
            wrDataLog[(w0 + k) & 255], 8'hA0 + k);
      expMem[ea] = 8'hA0 + 8'(k);
    end

    // streaming read from 4
    frameOpen();
    xfer(8'h50, rx);
    xfer(8'hB4, rx);
    for (int k = 0; k < 5; k++) begin
      int ea;
      ea = (4 + k > 6) ? (4 + k - 7) : (4 + k);
      xfer(8'h00, rx);
      check(rx == expMem[ea], "R6 stream read data", rx, expMem[ea]);
    end
    frameClose();

    // pointer above the wrap point counts modulo 16
    w0 = wrCnt;
    frameOpen();
    xfer(8'h50, rx);
    xfer(8'hCE, rx);
    for (int k = 0; k < 3; k++) xfer(8'h60 + 8'(k), rx);
    frameClose();
    check(wrAddrLog[w0 & 255] == 4'd14, "R5 high addr", wrAddrLog[w0 & 255], 14);
    check(wrAddrLog[(w0 + 1) & 255] == 4'd15, "R5 high addr", wrAddrLog[(w0 + 1) & 255], 15);
    check(wrAddrLog[(w0 + 2) & 255] == 4'd0, "R5 wrap 15 to 0", wrAddrLog[(w0 + 2) & 255], 0);
    expMem[14] = 8'h60; expMem[15] = 8'h61; expMem[0] = 8'h62;

    // busy blocks writes, pointer advances, reads allowed
    w0 = wrCnt;
    frameOpen();
    xfer(8'h50, rx);
    xfer(8'hC3, rx);
    busy = 1'b1;
    xfer(8'h11, rx);
    busy = 1'b0;
    xfer(8'h22, rx);
    frameClose();
    check(wrCnt == w0 + 1, "R8 busy suppressed one write", wrCnt, w0 + 1);
    check(wrAddrLog[w0 & 255] == 4'd4, "R8 pointer advanced under busy",
          wrAddrLog[w0 & 255], 4);
    expMem[4] = 8'h22;
    busy = 1'b1;
    readOne(4'd3, rx);
    check(rx == expMem[3], "R8 read while busy", rx, expMem[3]);
    readOne(4'd4, rx);
    check(rx == 8'h22, "R8 read while busy", rx, 8'h22);
    busy = 1'b0;

    // aborted frame then a fresh one
    w0 = wrCnt;
    frameOpen();
    xfer(8'h50, rx);
    xfer(8'hC7, rx);
    xferBits(8'hF0, 4, rx);
    frameClose();
    check(wrCnt == w0, "R9 partial byte dropped", wrCnt, w0);
    writeFrame(8'h50, 8'hC7, 8'h99);
    check(wrCnt == w0 + 1 && wrAddrLog[w0 & 255] == 4'd7 && wrDataLog[w0 & 255] == 8'h99,
          "R9 fresh frame after abort", wrDataLog[w0 & 255], 8'h99);
    expMem[7] = 8'h99;

    // sweep: write then read back every address
    for (int a = 0; a < 16; a++) begin
      logic [7:0] v;
      v = 8'((a * 29 + 3) & 8'hFF) ^ 8'h5A;
      writeFrame(8'h50, {4'hC, 4'(a)}, v);
      readOne(4'(a), rx);
      check(rx == v, "R4 R6 sweep readback", rx, v);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule